// File: doc/BRIEF.md
# Dual-Channel Auto-Reload PWM Generator

This block produces two pulse-width-modulated outputs from one free-running up-counter. Software programs a reload value that sets where every period begins; the counter climbs from that value to its all-ones maximum. On the next clock it returns to the reload value. Both channels therefore share the period and its leading edge. Each channel has its own duty register, which places that channel's trailing edge inside the shared period.

A duty value takes effect only at a period boundary. A control register gates each output and can invert each one. Changes to the control register act within one clock.

Software reaches the block through a small synchronous write port and a combinational read port with four addresses. The two PWM pins are meant to be routed straight to pads. Prescaling, clock selection and interrupts belong to the surrounding logic.

Top module: `dual_pwm_timer`

## Requirements
- R1: While reset is asserted and after it is released, the counter, the reload register, the control register, both duty registers and both active compare values are 00h, and both PWM outputs are 0.
- R2: On each clock edge the counter increments by one. The exception is the edge that finds it at FFh: that edge loads the reload value held before the edge. A reload of R gives a period of 256-R cycles.
- R3: Register addresses are 0 = control, 1 = reload, 2 = channel 0 duty, 3 = channel 1 duty. A write with `reg_wr` high is captured on the clock edge. The read data reflects the addressed register combinationally and returns the last value written. Control bits 7:6 and 3:2 always read 0.
- R4: Control bit 4 enables channel 0 and bit 5 enables channel 1. A channel whose enable bit is 0 drives its output low, whatever its polarity bit and duty value are.
- R5: With normal polarity and a channel enabled, the output is 0 while the counter is at or below the channel's active compare value. It is 1 while the counter is above that value. Compare values 01h to FEh follow this rule.
- R6: The edge that moves the counter from FFh to the reload value copies each duty register into that channel's active compare value. A duty write in the middle of a period leaves the rest of that period unchanged.
- R7: An active compare value of FFh forces the enabled channel's normal-polarity level to a constant 0. A value of 00h forces it to a constant 1.
- R8: Control bit 0 inverts channel 0 and bit 1 inverts channel 1. The inversion applies to the level, including forced levels. A write to a polarity bit shows on the output in the first cycle after the write edge, without waiting for a period boundary.
- R9: The two channels are independent. The duty, enable and polarity settings of one channel never change the output of the other channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 2 | Register select for both write and read |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed register (combinational) |
| pwm_o | output | 2 | PWM outputs; bit 0 is channel 0, bit 1 is channel 1 |

## Verification
The outputs are combinational functions of registered state. A control write therefore reaches `pwm_o` in the cycle right after its write edge, and a register write reaches `reg_rdata` from that same edge onward. A duty write changes the output only after the counter next leaves FFh, and a reload write first shapes the period that begins at that same edge. The bench drives inputs and samples outputs on falling edges. A model of the requirements in the bench advances on each rising edge, so every per-cycle comparison lines up with the edge that the requirement names. Directed checks wait on the model's counter to land a duty write in mid-period, then compare the output before and after the next reload.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;

  // number of PWM channels served by the shared counter
  localparam int NCH = 2;

  // control register field positions (decoded by the output stage)
  localparam int CTRL_EN_LSB  = 4;
  localparam int CTRL_POL_LSB = 0;

  // register port address width and map
  localparam int AW = 2;

  typedef enum logic [AW-1:0] {
    A_CTRL   = 2'd0,
    A_RELOAD = 2'd1,
    A_DUTY0  = 2'd2,
    A_DUTY1  = 2'd3
  } reg_addr_e;

endpackage

// File: rtl/dpwm_counter.sv
module dpwm_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] reload,
  output logic [W-1:0] cnt,
  output logic         wrap
);

  localparam logic [W-1:0] CNT_MAX = '1;
  localparam logic [W-1:0] CNT_ONE = {{(W-1){1'b0}}, 1'b1};

  // next value: step up, or jump back to the reload value at the top
  function automatic logic [W-1:0] next_count(input logic [W-1:0] cur,
                                               input logic [W-1:0] rel);
    if (cur == CNT_MAX) return rel;
    return cur + CNT_ONE;
  endfunction

  // period boundary event, shared by both channels
  assign wrap = (cnt == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= next_count(cnt, reload);
  end

  // R2: top of count returns to the previous reload value
  p_wrap_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt == $past(reload)));

  // R2: below the top, plain increment
  p_step_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> (cnt == $past(cnt) + CNT_ONE));

endmodule

// File: rtl/dpwm_regs.sv
module dpwm_regs
  import dpwm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [AW-1:0]           addr,
  input  logic [W-1:0]            wdata,
  output logic [W-1:0]            rdata,
  output logic [W-1:0]            reload,
  output logic [NCH-1:0][W-1:0]   duty,
  output logic [NCH-1:0]          ch_en,
  output logic [NCH-1:0]          ch_pol
);

  reg_addr_e        sel;
  logic [W-1:0]     ctrl_view;
  logic             wr_ctrl;
  logic             wr_reload;
  logic [NCH-1:0]   wr_duty;

  assign sel       = reg_addr_e'(addr);
  assign wr_ctrl   = wr_en && (sel == A_CTRL);
  assign wr_reload = wr_en && (sel == A_RELOAD);

  // control fields, stored separately; reserved bits are not stored at all
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ch_en  <= '0;
      ch_pol <= '0;
    end else if (wr_ctrl) begin
      ch_en  <= wdata[CTRL_EN_LSB  +: NCH];
      ch_pol <= wdata[CTRL_POL_LSB +: NCH];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         reload <= '0;
    else if (wr_reload) reload <= wdata;
  end

  // one duty register per channel, addressed consecutively
  for (genvar g = 0; g < NCH; g++) begin : g_duty
    assign wr_duty[g] = wr_en && (addr == AW'(int'(A_DUTY0) + g));

    always_ff @(posedge clk) begin
      if (!rst_n)          duty[g] <= '0;
      else if (wr_duty[g]) duty[g] <= wdata;
    end
  end

  // read view of the control register with reserved positions zero
  always_comb begin
    ctrl_view = '0;
    ctrl_view[CTRL_EN_LSB  +: NCH] = ch_en;
    ctrl_view[CTRL_POL_LSB +: NCH] = ch_pol;
  end

  always_comb begin
    unique case (sel)
      A_CTRL:   rdata = ctrl_view;
      A_RELOAD: rdata = reload;
      A_DUTY0:  rdata = duty[0];
      A_DUTY1:  rdata = duty[1];
      default:  rdata = '0;
    endcase
  end

  // R3: a reload write is visible after its edge
  p_reload_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reload |=> (reload == $past(wdata)));

  // R3: channel 0 duty write lands in the duty register
  p_duty0_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_duty[0] |=> (duty[0] == $past(wdata)));

  // R3: reserved control positions never read back as 1
  p_rsv_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == A_CTRL) |-> (rdata[7:6] == 2'b00 && rdata[3:2] == 2'b00));

  // R3: registers only change when written
  p_reload_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_reload |=> $stable(reload));

endmodule

// File: rtl/dpwm_channel.sv
module dpwm_channel #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wrap,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] duty,
  input  logic         en,
  input  logic         pol,
  output logic         pwm
);

  localparam logic [W-1:0] CMP_ALL1 = '1;
  localparam logic [W-1:0] CMP_ALL0 = '0;

  logic [W-1:0] cmp_q;      // active compare value for the running period
  logic         lvl_raw;    // normal-polarity level before gating
  logic         force_lo;   // compare at all-ones
  logic         force_hi;   // compare at zero

  // normal-polarity level for a counter / compare pair
  function automatic logic level_of(input logic [W-1:0] c,
                                    input logic [W-1:0] k);
    if (k == CMP_ALL1) return 1'b0;
    if (k == CMP_ALL0) return 1'b1;
    return (c > k);
  endfunction

  // duty value becomes active only at the period boundary
  always_ff @(posedge clk) begin
    if (!rst_n)    cmp_q <= '0;
    else if (wrap) cmp_q <= duty;
  end

  assign force_lo = (cmp_q == CMP_ALL1);
  assign force_hi = (cmp_q == CMP_ALL0);
  assign lvl_raw  = level_of(cnt, cmp_q);

  // polarity and enable act combinationally on registered state
  assign pwm = en & (lvl_raw ^ pol);

  // R6: compare is loaded with the pre-edge duty at the boundary
  p_cmp_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cmp_q == $past(duty)));

  // R6: compare holds through the period
  p_cmp_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(cmp_q));

  // R7: all-ones compare gives a constant low normal-polarity level
  p_force_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && force_lo) |-> (pwm == pol));

  // R7: zero compare gives a constant high normal-polarity level
  p_force_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && force_hi) |-> (pwm == !pol));

  // R5: counter at or below the compare keeps a normal output low
  p_low_below_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !pol && !force_hi && cnt <= cmp_q) |-> !pwm);

endmodule

// File: rtl/dual_pwm_timer.sv
module dual_pwm_timer
  import dpwm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic [1:0]    pwm_o
);

  logic [W-1:0]            reload;
  logic [NCH-1:0][W-1:0]   duty;
  logic [NCH-1:0]          ch_en;
  logic [NCH-1:0]          ch_pol;
  logic [W-1:0]            cnt;
  logic                    wrap;

  dpwm_regs #(.W(W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (reg_wr),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .rdata  (reg_rdata),
    .reload (reload),
    .duty   (duty),
    .ch_en  (ch_en),
    .ch_pol (ch_pol)
  );

  dpwm_counter #(.W(W)) u_counter (
    .clk    (clk),
    .rst_n  (rst_n),
    .reload (reload),
    .cnt    (cnt),
    .wrap   (wrap)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dpwm_channel #(.W(W)) u_ch (
      .clk   (clk),
      .rst_n (rst_n),
      .wrap  (wrap),
      .cnt   (cnt),
      .duty  (duty[g]),
      .en    (ch_en[g]),
      .pol   (ch_pol[g]),
      .pwm   (pwm_o[g])
    );

    // R4: a disabled channel stays low
    p_disabled_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_en[g] |-> !pwm_o[g]);
  end

  // R1: outputs low while in reset
  p_reset_low_r1: assert property (@(posedge clk)
    !rst_n |-> (pwm_o == '0));

endmodule

// File: tb/dual_pwm_timer_bench.sv
module dual_pwm_timer_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic [1:0] pwm;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  logic mon_on = 1'b0;

  // bench-side model state, advanced on rising edges
  logic [7:0] m_cnt = 8'd0, m_rel = 8'd0, m_ctrl = 8'd0;
  logic [7:0] m_duty0 = 8'd0, m_duty1 = 8'd0, m_cmp0 = 8'd0, m_cmp1 = 8'd0;

  always #4 clk = ~clk;   // 125 MHz

  dual_pwm_timer u_dual_pwm_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (wr),
    .reg_addr  (addr),
    .reg_wdata (wdata),
    .reg_rdata (rdata),
    .pwm_o     (pwm)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt <= 8'd0; m_rel <= 8'd0; m_ctrl <= 8'd0;
      m_duty0 <= 8'd0; m_duty1 <= 8'd0; m_cmp0 <= 8'd0; m_cmp1 <= 8'd0;
    end else begin
      if (wr) begin
        case (addr)
          2'd0: m_ctrl  <= wdata & 8'h33;
          2'd1: m_rel   <= wdata;
          2'd2: m_duty0 <= wdata;
          default: m_duty1 <= wdata;
        endcase
      end
      if (m_cnt == 8'hFF) begin
        m_cnt <= m_rel; m_cmp0 <= m_duty0; m_cmp1 <= m_duty1;
      end else begin
        m_cnt <= m_cnt + 8'd1;
      end
    end
  end

  function automatic logic expect_pin(input logic [7:0] c, input logic [7:0] k,
                                      input logic en, input logic pol);
    logic lvl;
    if (k == 8'hFF)      lvl = 1'b0;
    else if (k == 8'h00) lvl = 1'b1;
    else                 lvl = (c > k) ? 1'b1 : 1'b0;
    return en & (lvl ^ pol);
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h at cycle %0d", tag, got, exp, cyc);
    end
  endtask

  function automatic string tag_for(input logic [7:0] k, input logic en, input logic pol);
    if (!en) return "R4";
    if (k == 8'hFF || k == 8'h00) return "R7";
    if (pol) return "R8";
    return "R5";
  endfunction

  // per-cycle comparison against the model, both channels
  always @(negedge clk) begin
    if (mon_on) begin
      chk(tag_for(m_cmp0, m_ctrl[4], m_ctrl[0]), {31'd0, pwm[0]},
          {31'd0, expect_pin(m_cnt, m_cmp0, m_ctrl[4], m_ctrl[0])});
      chk(tag_for(m_cmp1, m_ctrl[5], m_ctrl[1]), {31'd0, pwm[1]},
          {31'd0, expect_pin(m_cnt, m_cmp1, m_ctrl[5], m_ctrl[1])});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 150000) begin
      total++; bad++;
      $display("FAIL watchdog got=%0d exp=<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] a, input logic [7:0] exp);
    @(negedge clk);
    addr = a;
    #1;
    chk(tag, {24'd0, rdata}, {24'd0, exp});
  endtask

  task automatic wait_cnt(input logic [7:0] v);
    do @(negedge clk); while (m_cnt != v);
  endtask

  logic [7:0] dlist [7] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hF0, 8'hFE, 8'hFF};
  logic [7:0] rlist [5] = '{8'h00, 8'h80, 8'hF0, 8'hFE, 8'hFF};
  logic [7:0] clist [4] = '{8'h33, 8'h31, 8'h12, 8'h23};

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", {30'd0, pwm}, 32'd0);
    rd_chk("R1", 2'd0, 8'h00);
    rd_chk("R1", 2'd1, 8'h00);
    rd_chk("R1", 2'd2, 8'h00);
    rd_chk("R1", 2'd3, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", {30'd0, pwm}, 32'd0);
    mon_on = 1'b1;

    // R3: register access, reserved bits read zero
    wr_reg(2'd0, 8'hFF);  rd_chk("R3", 2'd0, 8'h33);
    wr_reg(2'd1, 8'hA5);  rd_chk("R3", 2'd1, 8'hA5);
    wr_reg(2'd2, 8'h3C);  rd_chk("R3", 2'd2, 8'h3C);
    wr_reg(2'd3, 8'hC3);  rd_chk("R3", 2'd3, 8'hC3);
    rd_chk("R3", 2'd2, 8'h3C);
    wr_reg(2'd0, 8'h00);  rd_chk("R3", 2'd0, 8'h00);

    // sweep reload x duty x control patterns (R4, R5, R7, R8 via monitor)
    for (int ri = 0; ri < 5; ri++) begin
      for (int di = 0; di < 7; di++) begin
        wr_reg(2'd1, rlist[ri]);
        wr_reg(2'd2, dlist[di]);
        wr_reg(2'd3, dlist[6-di]);
        wr_reg(2'd0, clist[(ri*7+di)%4]);
        repeat (520) @(negedge clk);
      end
    end

    // R2: period length from reload, counted on the output
    begin
      int highs;
      wr_reg(2'd1, 8'hF0); wr_reg(2'd2, 8'hF7); wr_reg(2'd0, 8'h10);
      repeat (600) @(negedge clk);
      highs = 0;
      for (int i = 0; i < 64; i++) begin
        @(negedge clk);
        if (pwm[0]) highs++;
      end
      chk("R2", highs, 32);
    end

    // R6: mid-period duty write waits for the next period
    wr_reg(2'd1, 8'h00); wr_reg(2'd2, 8'h80); wr_reg(2'd0, 8'h10);
    repeat (600) @(negedge clk);
    wait_cnt(8'h10);
    wr = 1'b1; addr = 2'd2; wdata = 8'h20;
    @(negedge clk); wr = 1'b0;
    wait_cnt(8'h30);
    chk("R6", {31'd0, pwm[0]}, 32'd0);
    wait_cnt(8'h00);
    wait_cnt(8'h30);
    chk("R6", {31'd0, pwm[0]}, 32'd1);

    // R8: polarity flip shows in the next cycle, mid-period
    wr_reg(2'd2, 8'hFF);
    repeat (600) @(negedge clk);
    wait_cnt(8'h40);
    chk("R8", {31'd0, pwm[0]}, 32'd0);
    wr = 1'b1; addr = 2'd0; wdata = 8'h11;
    @(negedge clk); wr = 1'b0;
    chk("R8", {31'd0, pwm[0]}, 32'd1);

    // R9: channel 1 settings leave channel 0 alone
    wr_reg(2'd2, 8'h00); wr_reg(2'd0, 8'h10);
    repeat (600) @(negedge clk);
    chk("R9", {31'd0, pwm[0]}, 32'd1);
    wr_reg(2'd3, 8'hFF); wr_reg(2'd0, 8'h32);
    repeat (300) @(negedge clk);
    chk("R9", {30'd0, pwm}, 32'd3);

    mon_on = 1'b0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule